// File: doc/BRIEF.md
# Serial Command Port with Frame-Length Validation

This block is a 16-bit full-duplex serial peripheral for a command interface whose master may chain it with other 8-bit and 16-bit peripherals. The chip select, serial clock and serial data pins are brought into a fast system clock through synchronisers, and all edge detection happens in that clock domain. While chip select is low, the block sends a status word out on its serial output and takes command bits in on its serial input. Both directions run most significant bit first.

As soon as chip select falls, the serial output carries a pre-clock flag. This flag is an external fault input ORed with the serial input pin. From the first rising serial clock onward, the output carries the status word captured at the start of the frame, one bit per rising edge. After those 16 bits it repeats the bits it received, 16 clocks late, so that a neighbour further down the chain gets its own command.

A frame-length checker counts rising clocks with a variable modulus: 16 for the first word, then 8 for each word after it. When chip select rises, the last 16 received bits are committed to the command register, with a one-cycle strobe, only if the count ended on a word boundary and stayed at or below the frame limit. Any other frame is dropped, and the previous command is kept.

The control state machine has three states:
- `ST_IDLE`: chip select is high and the output is released.
- `ST_PRE`: chip select is low and no clock has arrived yet.
- `ST_SHIFT`: clocks are being counted.

It has these transitions:
- `ST_IDLE` goes to `ST_PRE` on a chip-select fall.
- `ST_PRE` goes to `ST_SHIFT` on the first rising clock.
- `ST_PRE` goes to `ST_IDLE` on a chip-select rise. This is an empty frame, and nothing is committed.
- `ST_SHIFT` goes to `ST_IDLE` on a chip-select rise. The commit decision is made here.
- Any state goes to `ST_IDLE` while enable is low.

Top module: `spi_frame_slave`

## Requirements
- R1: `so_oe` is 0 whenever chip select has been high for more than the synchroniser delay, and it is 1 throughout a frame.
- R2: Before the first rising serial clock of a frame, `so_out` equals `fault_flag` OR the synchronised serial input.
- R3: After rising clock k of a frame, for k from 1 to 16, `so_out` equals bit 16-k of the status word captured when chip select fell. Bit 15 comes first.
- R4: After rising clock k, for k above 16, `so_out` equals serial-input bit k-16 of the same frame. Bits are counted from 1 in arrival order.
- R5: Serial input is sampled on falling serial clocks. A committed word holds the last 16 sampled bits, with the earliest of them in bit 15.
- R6: A frame with N rising clocks is valid when N is at least 16, N is a multiple of 8 and N is at most 255. A valid frame updates `cmd_word` and raises `cmd_strobe` for exactly one system clock after chip select rises.
- R7: A frame with 0 clocks, fewer than 16 clocks, a count that is not a multiple of 8, or more than 255 clocks produces no strobe and leaves `cmd_word` unchanged.
- R8: A change on `status_word` during a frame does not alter the bits sent in that frame. The next frame sends the new value.
- R9: Reset, or `enable` low, clears `cmd_word` to 0 and drops `cmd_strobe`. While `enable` is low, `so_oe` stays 0 even if chip select is low.
- R10: `cmd_word` changes only in a cycle where `cmd_strobe` is 1, or in the cycle after `enable` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. It must run at least 8 times the serial clock. |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| enable | input | 1 | Active-high enable. Low clears and idles the block. |
| sclk_in | input | 1 | Serial clock from the master, idle low |
| si_in | input | 1 | Serial data input |
| csb_in | input | 1 | Active-low chip select |
| fault_flag | input | 1 | Latched fault, sent as the pre-clock bit |
| status_word | input | 16 | Status word to send in the next frame |
| so_out | output | 1 | Serial data output |
| so_oe | output | 1 | Output enable for the serial output pad. 0 means high impedance. |
| cmd_word | output | 16 | Last committed command word |
| cmd_strobe | output | 1 | One-cycle pulse when `cmd_word` is updated |

## Verification
The assertions assume the following about the inputs:
- The serial clock is low when chip select changes.
- No serial clock edge coincides with a chip-select edge after synchronisation.
- Each serial input bit is stable for several system clocks around the falling clock edge that samples it.

The stimulus keeps within these assumptions. It drives every pin on the falling system clock, holds each serial clock phase for 8 or more system clocks, and changes the serial input 4 system clocks before the rising serial clock. It parks the serial clock low for several cycles before moving chip select. Frame lengths cover:
- the valid counts 16, 24, 32 and 248;
- the invalid counts 0, 8, 12, 20 and 256.

// File: rtl/spi_fs_pkg.sv
package spi_fs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRE   = 2'd1,
        ST_SHIFT = 2'd2
    } fs_state_t;

    localparam int FS_PIN_COUNT = 3;
endpackage

// File: rtl/spi_fs_sync.sv
module spi_fs_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            for (int s = STAGES - 1; s > 0; s--) begin
                stg[s] <= stg[s-1];
            end
            stg[0] <= d;
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_fs_lencheck.sv
module spi_fs_lencheck #(
    parameter int FIRST_LEN = 16,
    parameter int STEP_LEN  = 8,
    parameter int MAX_CLKS  = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic frame_ok
);
    localparam int            PW         = $clog2(FIRST_LEN);
    localparam int            TW         = $clog2(MAX_CLKS + 2);
    localparam logic [TW-1:0] TOT_SAT    = TW'(MAX_CLKS + 1);
    localparam logic [TW-1:0] TOT_MAX    = TW'(MAX_CLKS);
    localparam logic [PW-1:0] FIRST_LAST = PW'(FIRST_LEN - 1);
    localparam logic [PW-1:0] STEP_LAST  = PW'(STEP_LEN - 1);

    logic [PW-1:0] phase;
    logic [TW-1:0] total;
    logic          first_done;
    logic          on_bound;
    logic [PW-1:0] phase_last;

    // modulus is FIRST_LEN for the first word, STEP_LEN afterwards
    assign phase_last = first_done ? STEP_LAST : FIRST_LAST;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase      <= '0;
            total      <= '0;
            first_done <= 1'b0;
            on_bound   <= 1'b0;
        end else if (clr) begin
            phase      <= '0;
            total      <= '0;
            first_done <= 1'b0;
            on_bound   <= 1'b0;
        end else if (tick) begin
            if (phase == phase_last) begin
                phase      <= '0;
                first_done <= 1'b1;
                on_bound   <= 1'b1;
            end else begin
                phase    <= phase + 1'b1;
                on_bound <= 1'b0;
            end
            if (total != TOT_SAT) begin
                total <= total + 1'b1;
            end
        end
    end

    assign frame_ok = on_bound && (total <= TOT_MAX);
endmodule

// File: rtl/spi_fs_shifter.sv
module spi_fs_shifter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             in_tick,
    input  logic             in_bit,
    input  logic             out_tick,
    output logic [WIDTH-1:0] word,
    output logic             out_bit
);
    logic [WIDTH-1:0] sh;
    logic             out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh    <= '0;
            out_q <= 1'b0;
        end else if (clr) begin
            sh    <= '0;
            out_q <= 1'b0;
        end else if (load) begin
            sh    <= load_val;
            out_q <= 1'b0;
        end else begin
            if (out_tick) begin
                out_q <= sh[WIDTH-1];
            end
            if (in_tick) begin
                sh <= {sh[WIDTH-2:0], in_bit};
            end
        end
    end

    assign word    = sh;
    assign out_bit = out_q;
endmodule

// File: rtl/spi_frame_slave.sv
module spi_frame_slave
    import spi_fs_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int STEP_W      = 8,
    parameter int MAX_CLKS    = 255,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sclk_in,
    input  logic              si_in,
    input  logic              csb_in,
    input  logic              fault_flag,
    input  logic [WORD_W-1:0] status_word,
    output logic              so_out,
    output logic              so_oe,
    output logic [WORD_W-1:0] cmd_word,
    output logic              cmd_strobe
);
    localparam logic [FS_PIN_COUNT-1:0] PIN_IDLE = 3'b100;

    logic [FS_PIN_COUNT-1:0] pins_s;
    logic csb_s, sclk_s, si_s;
    logic csb_d, sclk_d;
    logic csb_fall, csb_rise, sclk_rise, sclk_fall;
    fs_state_t state, state_nx;
    logic rise_t, fall_t, load_t, clr_t, frame_ok, commit, tx_bit;
    logic [WORD_W-1:0] rx_word;

    spi_fs_sync #(
        .WIDTH  (FS_PIN_COUNT),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({csb_in, sclk_in, si_in}),
        .q    (pins_s)
    );

    assign csb_s  = pins_s[2];
    assign sclk_s = pins_s[1];
    assign si_s   = pins_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csb_d  <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            csb_d  <= csb_s;
            sclk_d <= sclk_s;
        end
    end

    assign csb_fall  = csb_d & ~csb_s;
    assign csb_rise  = ~csb_d & csb_s;
    assign sclk_rise = ~sclk_d & sclk_s;
    assign sclk_fall = sclk_d & ~sclk_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (csb_fall) state_nx = ST_PRE;
            ST_PRE: begin
                if (csb_rise)       state_nx = ST_IDLE;
                else if (sclk_rise) state_nx = ST_SHIFT;
            end
            ST_SHIFT: if (csb_rise) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
        if (!enable) state_nx = ST_IDLE;
    end

    assign load_t = (state == ST_IDLE) && csb_fall;
    assign rise_t = (state != ST_IDLE) && sclk_rise && !csb_rise;
    assign fall_t = (state == ST_SHIFT) && sclk_fall && !csb_rise;
    assign clr_t  = !enable;

    spi_fs_lencheck #(
        .FIRST_LEN(WORD_W),
        .STEP_LEN (STEP_W),
        .MAX_CLKS (MAX_CLKS)
    ) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_t || load_t),
        .tick    (rise_t),
        .frame_ok(frame_ok)
    );

    spi_fs_shifter #(
        .WIDTH(WORD_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_t),
        .load    (load_t),
        .load_val(status_word),
        .in_tick (fall_t),
        .in_bit  (si_s),
        .out_tick(rise_t),
        .word    (rx_word),
        .out_bit (tx_bit)
    );

    assign commit = (state == ST_SHIFT) && csb_rise && frame_ok && enable;

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_word   <= '0;
            cmd_strobe <= 1'b0;
        end else if (!enable) begin
            cmd_word   <= '0;
            cmd_strobe <= 1'b0;
        end else begin
            cmd_strobe <= commit;
            if (commit) cmd_word <= rx_word;
        end
    end

    // serial output selection
    always_comb begin
        so_oe = 1'b0;
        so_out = 1'b0;
        unique case (state)
            ST_IDLE:  begin so_oe = 1'b0; so_out = 1'b0; end
            ST_PRE:   begin so_oe = 1'b1; so_out = fault_flag | si_s; end
            ST_SHIFT: begin so_oe = 1'b1; so_out = tx_bit; end
            default:  begin so_oe = 1'b0; so_out = 1'b0; end
        endcase
    end
endmodule

// File: rtl/spi_frame_slave_chk.sv
module spi_frame_slave_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              csb_s,
    input logic              so_oe,
    input logic [WORD_W-1:0] cmd_word,
    input logic              cmd_strobe
);
    assert_idle_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (csb_s && $past(csb_s)) |-> !so_oe);

    assert_oe_after_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_oe) |-> !$past(csb_s));

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |=> !cmd_strobe);

    assert_strobe_after_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |-> $past(csb_s));

    assert_enable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cmd_word == '0 && !so_oe && !cmd_strobe));

    assert_cmd_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_word != $past(cmd_word)) |-> (cmd_strobe || !$past(enable)));
endmodule

bind spi_frame_slave spi_frame_slave_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .csb_s     (csb_s),
    .so_oe     (so_oe),
    .cmd_word  (cmd_word),
    .cmd_strobe(cmd_strobe)
);

// File: tb/sim_spi_frame_slave.sv
module sim_spi_frame_slave;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, enable, sclk_in, si_in, csb_in, fault_flag;
    logic [15:0] status_word;
    logic        so_out, so_oe, cmd_strobe;
    logic [15:0] cmd_word;

    int          checks = 0;
    int          errors = 0;
    int          strobes = 0;
    bit          busy = 1'b1;
    bit          done = 1'b0;
    logic [15:0] exp_cmd = 16'h0000;

    spi_frame_slave u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sclk_in(sclk_in),
        .si_in(si_in), .csb_in(csb_in), .fault_flag(fault_flag),
        .status_word(status_word), .so_out(so_out), .so_oe(so_oe),
        .cmd_word(cmd_word), .cmd_strobe(cmd_strobe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) if (rst_n && cmd_strobe) strobes++;

    // reference comparison on every clock while the port is idle
    always @(negedge clk) begin
        if (rst_n && !busy && !done) begin
            chk(cmd_word == exp_cmd, "R5/R7 command vs reference", cmd_word, exp_cmd);
            chk(so_oe == 1'b0, "R1 idle output released", so_oe, 0);
        end
    end

    task automatic frame(input int n, input logic pre_si, input bit mid_change);
        logic        bits[$];
        logic [15:0] stat;
        logic [15:0] expw;
        bit          valid;
        int          s0;
        for (int i = 0; i < n; i++) bits.push_back(1'($urandom_range(0, 1)));
        busy = 1'b1;
        stat = status_word;
        si_in = pre_si;
        wait_n(1);
        csb_in = 1'b0;
        wait_n(10);
        chk(so_oe == 1'b1, "R1 output driven in frame", so_oe, 1);
        chk(so_out == (fault_flag | pre_si), "R2 pre-clock bit", so_out, fault_flag | pre_si);
        s0 = strobes;
        for (int k = 1; k <= n; k++) begin
            si_in = bits[k-1];
            wait_n(4);
            sclk_in = 1'b1;
            wait_n(6);
            if (k <= 16)
                chk(so_out == stat[16-k], mid_change ? "R8 frozen status bit" : "R3 status bit",
                    so_out, stat[16-k]);
            else
                chk(so_out == bits[k-17], "R4 pass-through bit", so_out, bits[k-17]);
            if (mid_change && k == 5) status_word = ~stat;
            wait_n(2);
            sclk_in = 1'b0;
            wait_n(8);
        end
        si_in = 1'b0;
        wait_n(4);
        csb_in = 1'b1;
        wait_n(10);
        valid = (n >= 16) && (n % 8 == 0) && (n <= 255);
        if (valid) begin
            for (int j = 0; j < 16; j++) expw[15-j] = bits[n-16+j];
            exp_cmd = expw;
            chk(strobes - s0 == 1, "R6 one strobe for valid frame", strobes - s0, 1);
            chk(cmd_word == expw, "R5 last 16 bits committed", cmd_word, expw);
        end else begin
            chk(strobes - s0 == 0, "R7 no strobe for bad frame", strobes - s0, 0);
            chk(cmd_word == exp_cmd, "R7 command kept", cmd_word, exp_cmd);
        end
        chk(so_oe == 1'b0, "R1 released after frame", so_oe, 0);
        busy = 1'b0;
        wait_n(3);
    endtask

    initial begin
        rst_n = 1'b0; enable = 1'b1; sclk_in = 1'b0; si_in = 1'b0; csb_in = 1'b1;
        fault_flag = 1'b0; status_word = 16'hA5C3;
        wait_n(5);
        chk(so_oe == 1'b0, "R9 reset output released", so_oe, 0);
        chk(cmd_word == 16'h0, "R9 reset command zero", cmd_word, 0);
        chk(cmd_strobe == 1'b0, "R9 reset no strobe", cmd_strobe, 0);
        rst_n = 1'b1;
        wait_n(5);
        busy = 1'b0;

        frame(16, 1'b0, 1'b0);
        status_word = 16'h3C96;
        frame(16, 1'b0, 1'b0);
        fault_flag = 1'b1;
        frame(16, 1'b0, 1'b0);
        fault_flag = 1'b0;
        frame(24, 1'b1, 1'b0);
        frame(32, 1'b0, 1'b0);
        frame(12, 1'b0, 1'b0);
        frame(8, 1'b0, 1'b0);
        frame(20, 1'b0, 1'b0);
        frame(0, 1'b0, 1'b0);
        frame(256, 1'b0, 1'b0);
        frame(248, 1'b0, 1'b0);
        status_word = 16'h5A0F;
        frame(16, 1'b0, 1'b1);
        frame(16, 1'b0, 1'b0);

        // enable low clears command and keeps output released
        busy = 1'b1;
        enable = 1'b0;
        wait_n(4);
        chk(cmd_word == 16'h0, "R9 enable low clears command", cmd_word, 0);
        csb_in = 1'b0;
        wait_n(10);
        chk(so_oe == 1'b0, "R9 no drive while disabled", so_oe, 0);
        csb_in = 1'b1;
        wait_n(5);
        enable = 1'b1;
        exp_cmd = 16'h0;
        wait_n(5);
        busy = 1'b0;
        frame(16, 1'b0, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule